// File: doc/BRIEF.md
# Trimmed Oscillator Divider with Frequency-Test Output

This block turns a 32,768 Hz oscillator enable into one-second ticks and into roughly evenly spaced hundredths ticks. A signed 6-bit calibration field corrects crystal error digitally. It does this by changing the length of selected seconds at the divide-by-256 stage, without touching the oscillator itself. A private position counter walks through a 64-minute correction cycle. In each of the first 2N minutes of that cycle, the opening second is made shorter or longer by a fixed number of oscillator cycles. N is the calibration magnitude.

The block also drives a 512 Hz square wave for frequency measurement. This wave comes from its own untrimmed counter, so the calibration value never shows on it. The wave is gated by the test-mode qualifiers. A halt input freezes all counting. A one-cycle divider-reset strobe clears the whole chain and the cycle position; it is meant to be raised whenever the time registers are written. All three outputs are single-cycle pulses or levels that are registered in the system clock domain.

Top module: `osc_cal_divider`

## Requirements
- R1: After the reset is released, and until enables arrive, `sec_tick`, `centi_tick` and `ftest_out` are low.
- R2: An untrimmed second lasts exactly 2^(PRE_W+HI_W) counted enables (32,768 by default). An enable counts when `osc_en` is high, `halt` is low and `div_rst` is low. `sec_tick` pulses for one cycle, one clock after the enable that completes the second.
- R3: The calibration magnitude N is `cal_ctrl[4:0]`. A second is trimmed exactly when it is second 0 of its minute and the minute index within the 64-minute cycle is below 2N. Seconds are counted from the last divider reset, with SEC_PER_MIN seconds to a minute. N = 0 trims nothing.
- R4: With `cal_ctrl[5]` = 1 (speed up), a trimmed second is 2^PRE_W enables shorter (256 by default).
- R5: With `cal_ctrl[5]` = 0 (slow down), a trimmed second is 2^(PRE_W-1) enables longer (128 by default).
- R6: While `halt` is high, no enable is counted, no tick is produced and `ftest_out` is low. When `halt` clears, counting resumes from the held state.
- R7: Cycles with `osc_en` low do not advance any counter.
- R8: A `div_rst` strobe clears the divider, the hundredths spreading, the frequency-test counter and the 64-minute position. The cycle after the strobe has all outputs low.
- R9: Every `sec_tick` comes with a `centi_tick`. The other hundredths pulses in a second come from an accumulator that adds CENTI_PER_SEC on each divide-by-256 stage step and is capped at CENTI_PER_SEC-1 pulses. A second of K stage steps therefore gives min(floor((K-1)*CENTI_PER_SEC/2^HI_W), CENTI_PER_SEC-1)+1 pulses, which is CENTI_PER_SEC for a full second.
- R10: When qualified, `ftest_out` equals bit FT_W of the count of counted enables since the last divider reset. This toggles every 2^FT_W enables, which is 512 Hz by default. The output is qualified when `ftest_en`=1, `alarm_out_en`=0, `sqw_en`=0, `wdog_idle`=1 and `halt`=0.
- R11: The value of `cal_ctrl` has no effect on `ftest_out`.
- R12: When any qualifier of R10 is not met, `ftest_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| halt | input | 1 | Freezes all counting while high |
| div_rst | input | 1 | One-cycle strobe that clears the divider chain |
| cal_ctrl | input | 6 | Bit 5 sign (1 = faster), bits 4:0 trim magnitude |
| ftest_en | input | 1 | Frequency-test request |
| alarm_out_en | input | 1 | Alarm output owns the pin; blocks the test output |
| sqw_en | input | 1 | Square wave owns the pin; blocks the test output |
| wdog_idle | input | 1 | Watchdog setting is zero; required for the test output |
| sec_tick | output | 1 | One-cycle pulse per second |
| centi_tick | output | 1 | One-cycle hundredths pulse |
| ftest_out | output | 1 | Untrimmed 512 Hz test square wave |

## Verification
The bench runs a scaled divider (8 enables per stage, 4 stages, 2-second minutes) through the full 64-minute cycle plus its wrap, for both signs and for magnitudes 0, 1, 6, 15 and 31. Every second length is compared with the arithmetic schedule. A design that stretched the wrong second or the wrong number of minutes, swapped the step sizes, or failed to wrap the minute position would misreport a length there. Sparse enables and a long halt in mid-second catch counting that ignores the qualifier. Back-to-back runs start with a divider reset taken in mid-second, which exposes a chain or cycle position that is only partly cleared. The test output is checked on every cycle against the enable count under nonzero trims and with each qualifier dropped, so a wave derived from the trimmed chain, or a leaky gate, is caught.

// File: rtl/osc_div_pkg.sv
package osc_div_pkg;

  // Correction applied to the second currently being counted
  typedef enum logic [1:0] {
    TRIM_NONE = 2'd0,
    TRIM_FAST = 2'd1,   // one stage step removed
    TRIM_SLOW = 2'd2    // first stage step stretched by half
  } trim_e;

  localparam int CAL_MAG_W = 5;   // magnitude field width
  localparam int CAL_W     = CAL_MAG_W + 1;
  localparam int CYC_MIN_W = 6;   // 64-minute correction cycle

endpackage

// File: rtl/odc_trim_sched.sv
module odc_trim_sched
  import osc_div_pkg::*;
#(
  parameter int SEC_PER_MIN = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_rst,
  input  logic             sec_tick,
  input  logic [CAL_W-1:0] cal,
  output trim_e            trim
);

  localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;

  logic                 at_first_sec;
  logic                 min_step;
  logic [CYC_MIN_W-1:0] min_q, min_d;
  logic [CAL_MAG_W-1:0] mag;
  logic                 in_window;

  // Position of the current second inside its minute
  if (SEC_PER_MIN > 1) begin : g_sec
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
    logic [SEC_W-1:0] sec_q, sec_d;

    always_comb begin
      sec_d = sec_q;
      if (div_rst)       sec_d = '0;
      else if (sec_tick) sec_d = (sec_q == SEC_LAST) ? '0 : sec_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sec_q <= '0;
      else        sec_q <= sec_d;
    end

    assign at_first_sec = (sec_q == '0);
    assign min_step     = sec_tick && (sec_q == SEC_LAST);
  end else begin : g_nosec
    assign at_first_sec = 1'b1;
    assign min_step     = sec_tick;
  end

  // Free-running minute position within the correction cycle
  always_comb begin
    min_d = min_q;
    if (div_rst)       min_d = '0;
    else if (min_step) min_d = min_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) min_q <= '0;
    else        min_q <= min_d;
  end

  assign mag       = cal[CAL_MAG_W-1:0];
  assign in_window = at_first_sec && (min_q < {mag, 1'b0});

  always_comb begin
    trim = TRIM_NONE;
    if (in_window) trim = cal[CAL_W-1] ? TRIM_FAST : TRIM_SLOW;
  end

endmodule

// File: rtl/odc_stage_div.sv
module odc_stage_div
  import osc_div_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int HI_W  = 7
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  div_rst,
  input  logic  adv,
  input  trim_e trim,
  output logic  stage_tick,
  output logic  sec_tick
);

  localparam int PRE_CW = PRE_W + 1;
  localparam logic [PRE_CW-1:0] PRE_END      = PRE_CW'(2**PRE_W - 1);
  localparam logic [PRE_CW-1:0] PRE_END_LONG = PRE_CW'(2**PRE_W + 2**(PRE_W-1) - 1);
  localparam logic [HI_W-1:0]   HI_END       = HI_W'(2**HI_W - 1);
  localparam logic [HI_W-1:0]   HI_END_FAST  = HI_W'(2**HI_W - 2);

  logic [PRE_CW-1:0] pre_q, pre_d, pre_lim;
  logic [HI_W-1:0]   hi_q, hi_d, hi_lim;

  // Stage limits follow the trim of the second being counted
  always_comb begin
    pre_lim = PRE_END;
    if (trim == TRIM_SLOW && hi_q == '0) pre_lim = PRE_END_LONG;
    hi_lim = (trim == TRIM_FAST) ? HI_END_FAST : HI_END;
  end

  // Compare with >= so a limit change in mid-stage cannot skip a wrap
  assign stage_tick = adv && (pre_q >= pre_lim);
  assign sec_tick   = stage_tick && (hi_q >= hi_lim);

  always_comb begin
    pre_d = pre_q;
    hi_d  = hi_q;
    if (div_rst) begin
      pre_d = '0;
      hi_d  = '0;
    end else if (adv) begin
      pre_d = stage_tick ? '0 : pre_q + 1'b1;
      if (sec_tick)        hi_d = '0;
      else if (stage_tick) hi_d = hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      hi_q  <= '0;
    end else begin
      pre_q <= pre_d;
      hi_q  <= hi_d;
    end
  end

endmodule

// File: rtl/odc_centi.sv
module odc_centi #(
  parameter int HI_W          = 7,
  parameter int CENTI_PER_SEC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_rst,
  input  logic stage_tick,
  input  logic sec_tick,
  output logic centi_tick
);

  localparam int STAGES = 2**HI_W;
  localparam int ACC_W  = HI_W + 1;
  localparam int CC_W   = (CENTI_PER_SEC > 1) ? $clog2(CENTI_PER_SEC) : 1;
  localparam logic [ACC_W-1:0] STEP    = ACC_W'(CENTI_PER_SEC);
  localparam logic [ACC_W-1:0] MODULUS = ACC_W'(STAGES);
  localparam logic [CC_W-1:0]  CC_CAP  = CC_W'(CENTI_PER_SEC - 1);

  logic [ACC_W-1:0] acc_q, acc_d, acc_sum;
  logic [CC_W-1:0]  cc_q, cc_d;
  logic             pulse_q, pulse_d;

  assign acc_sum = acc_q + STEP;

  always_comb begin
    acc_d   = acc_q;
    cc_d    = cc_q;
    pulse_d = 1'b0;
    if (div_rst) begin
      acc_d = '0;
      cc_d  = '0;
    end else if (sec_tick) begin
      acc_d   = '0;
      cc_d    = '0;
      pulse_d = 1'b1;
    end else if (stage_tick) begin
      if (acc_sum >= MODULUS) begin
        acc_d = acc_sum - MODULUS;
        if (cc_q < CC_CAP) begin
          pulse_d = 1'b1;
          cc_d    = cc_q + 1'b1;
        end
      end else begin
        acc_d = acc_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cc_q    <= '0;
      pulse_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      cc_q    <= cc_d;
      pulse_q <= pulse_d;
    end
  end

  assign centi_tick = pulse_q;

endmodule

// File: rtl/odc_ftest.sv
module odc_ftest #(
  parameter int FT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_rst,
  input  logic adv,
  input  logic qual,
  output logic ftest_out
);

  logic [FT_W-1:0] cnt_q, cnt_d;
  logic            phase_q, phase_d;
  logic            out_q;

  // Untrimmed counter: calibration never reaches this path
  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (div_rst) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == '1) phase_d = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      out_q   <= qual && phase_d;
    end
  end

  assign ftest_out = out_q;

endmodule

// File: rtl/osc_cal_divider.sv
module osc_cal_divider
  import osc_div_pkg::*;
#(
  parameter int PRE_W         = 8,
  parameter int HI_W          = 7,
  parameter int SEC_PER_MIN   = 60,
  parameter int CENTI_PER_SEC = 100,
  parameter int FT_W          = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             halt,
  input  logic             div_rst,
  input  logic [CAL_W-1:0] cal_ctrl,
  input  logic             ftest_en,
  input  logic             alarm_out_en,
  input  logic             sqw_en,
  input  logic             wdog_idle,
  output logic             sec_tick,
  output logic             centi_tick,
  output logic             ftest_out
);

  logic  rst_meta_q, rst_core_n;
  logic  adv, ft_qual;
  trim_e trim;
  logic  stage_c, sec_c;
  logic  sec_q;

  // Reset asserts asynchronously, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  assign adv     = osc_en && !halt && !div_rst;
  assign ft_qual = ftest_en && !alarm_out_en && !sqw_en && wdog_idle && !halt;

  odc_trim_sched #(
    .SEC_PER_MIN(SEC_PER_MIN)
  ) u_sched (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .div_rst (div_rst),
    .sec_tick(sec_c),
    .cal     (cal_ctrl),
    .trim    (trim)
  );

  odc_stage_div #(
    .PRE_W(PRE_W),
    .HI_W (HI_W)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .div_rst   (div_rst),
    .adv       (adv),
    .trim      (trim),
    .stage_tick(stage_c),
    .sec_tick  (sec_c)
  );

  odc_centi #(
    .HI_W         (HI_W),
    .CENTI_PER_SEC(CENTI_PER_SEC)
  ) u_centi (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .div_rst   (div_rst),
    .stage_tick(stage_c),
    .sec_tick  (sec_c),
    .centi_tick(centi_tick)
  );

  odc_ftest #(
    .FT_W(FT_W)
  ) u_ft (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .div_rst  (div_rst),
    .adv      (adv),
    .qual     (ft_qual),
    .ftest_out(ftest_out)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) sec_q <= 1'b0;
    else             sec_q <= sec_c;
  end

  assign sec_tick = sec_q;

endmodule

// File: rtl/osc_cal_divider_chk.sv
module osc_cal_divider_chk #(
  parameter int PRE_W = 8,
  parameter int HI_W  = 7
) (
  input logic clk,
  input logic rst_n,
  input logic osc_en,
  input logic halt,
  input logic div_rst,
  input logic ftest_en,
  input logic sec_tick,
  input logic centi_tick,
  input logic ftest_out
);

  localparam int LW       = PRE_W + HI_W + 2;
  localparam int LEN_BASE = 2**(PRE_W + HI_W);
  localparam int LEN_MIN  = LEN_BASE - 2**PRE_W;
  localparam int LEN_MAX  = LEN_BASE + 2**(PRE_W-1);

  logic [LW-1:0] len_q;
  logic          adv;

  assign adv = osc_en && !halt && !div_rst;

  // Independent count of enables since the last second boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        len_q <= '0;
    else if (div_rst)  len_q <= '0;
    else if (sec_tick) len_q <= adv ? LW'(1) : '0;
    else if (adv)      len_q <= len_q + 1'b1;
  end

  p_sec_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (len_q >= LW'(LEN_MIN)) && (len_q <= LW'(LEN_MAX)));

  p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |-> (len_q < LW'(LEN_MAX)));

  p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt) |-> !sec_tick && !centi_tick && !ftest_out);

  p_idle_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(osc_en) |-> !sec_tick && !centi_tick);

  p_divrst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(div_rst) |-> !sec_tick && !centi_tick && !ftest_out);

  p_sec_has_centi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> centi_tick);

  p_ft_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ftest_en) |-> !ftest_out);

endmodule

bind osc_cal_divider osc_cal_divider_chk #(
  .PRE_W(PRE_W),
  .HI_W (HI_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .osc_en    (osc_en),
  .halt      (halt),
  .div_rst   (div_rst),
  .ftest_en  (ftest_en),
  .sec_tick  (sec_tick),
  .centi_tick(centi_tick),
  .ftest_out (ftest_out)
);

// File: tb/osc_cal_divider_tb.sv
module osc_cal_divider_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PRE_W  = 3;
  localparam int HI_W   = 2;
  localparam int SPM    = 2;
  localparam int CENTI  = 3;
  localparam int FT_W   = 2;
  localparam int STAGES = 2**HI_W;
  localparam int BASE   = 2**(PRE_W + HI_W);
  localparam int WD_CYCLES = 190000;

  logic       clk;
  logic       rst_n;
  logic       osc_en, halt, div_rst;
  logic [5:0] cal_ctrl;
  logic       ftest_en, alarm_out_en, sqw_en, wdog_idle;
  logic       sec_tick, centi_tick, ftest_out;

  int  vecs  = 0;
  int  fails = 0;
  bit  done  = 0;

  osc_cal_divider #(
    .PRE_W(PRE_W), .HI_W(HI_W), .SEC_PER_MIN(SPM),
    .CENTI_PER_SEC(CENTI), .FT_W(FT_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .halt(halt),
    .div_rst(div_rst), .cal_ctrl(cal_ctrl), .ftest_en(ftest_en),
    .alarm_out_en(alarm_out_en), .sqw_en(sqw_en), .wdog_idle(wdog_idle),
    .sec_tick(sec_tick), .centi_tick(centi_tick), .ftest_out(ftest_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit trimmed(input logic [5:0] c, input int s);
    int m;
    m = (s / SPM) % 64;
    return ((s % SPM) == 0) && (m < 2 * int'(c[4:0]));
  endfunction

  function automatic int exp_len(input logic [5:0] c, input int s);
    if (!trimmed(c, s)) return BASE;
    return c[5] ? BASE - 2**PRE_W : BASE + 2**(PRE_W-1);
  endfunction

  function automatic int exp_centi(input logic [5:0] c, input int s);
    int k, v;
    k = (trimmed(c, s) && c[5]) ? STAGES - 1 : STAGES;
    v = ((k - 1) * CENTI) / STAGES;
    if (v > CENTI - 1) v = CENTI - 1;
    return v + 1;
  endfunction

  // One measured run: divider reset, then nsec seconds checked one by one
  task automatic run(input logic [5:0] c, input int nsec, input int per,
                     input int st_from, input int st_len, input logic [3:0] q);
    int    cnt, nft, s, cc, cyc, el, ec, efq;
    bit    lq, en, stp;
    string tag, ftag;
    @(negedge clk);
    div_rst = 1'b1; osc_en = 1'b0; halt = 1'b0; cal_ctrl = c;
    {ftest_en, alarm_out_en, sqw_en, wdog_idle} = q;
    cnt = 0; nft = 0; s = 0; cc = 0; cyc = 0; lq = 1'b0;
    @(negedge clk);
    chk(!sec_tick && !centi_tick && !ftest_out, "R8 outputs after strobe",
        {sec_tick, centi_tick, ftest_out}, 0);
    div_rst = 1'b0;
    while (s < nsec) begin
      // drive next edge
      cyc++;
      en  = (cyc % per) == 0;
      stp = (cyc >= st_from) && (cyc < st_from + st_len);
      osc_en = en; halt = stp;
      if (en && !stp) begin cnt++; nft++; end
      lq = q[3] && !q[2] && !q[1] && q[0] && !stp;
      @(negedge clk);
      // sample result of that edge
      if (centi_tick) cc++;
      efq = lq ? ((nft >> FT_W) & 1) : 0;
      if (stp)          ftag = "R6 ftest during halt";
      else if (!lq)     ftag = "R12 ftest gated";
      else if (c != 0)  ftag = "R11 ftest under trim";
      else              ftag = "R10 ftest phase";
      chk(int'(ftest_out) == efq, ftag, int'(ftest_out), efq);
      if (sec_tick) begin
        el = exp_len(c, s);
        if (s == 0)               tag = "R8 first second after strobe";
        else if (per > 1)         tag = "R7 sparse enables";
        else if (st_len > 0)      tag = "R6 halt resume";
        else if (trimmed(c, s))   tag = c[5] ? "R4 fast trim length" : "R5 slow trim length";
        else if (c[4:0] != 0)     tag = "R3 untrimmed second in schedule";
        else                      tag = "R2 plain second length";
        chk(cnt == el, tag, cnt, el);
        ec = exp_centi(c, s);
        chk(cc == ec, "R9 hundredths per second", cc, ec);
        s++; cnt = 0; cc = 0;
      end
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (R2 progress): got %0d cycles expected completion", WD_CYCLES);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] cals [10];
    cals = '{6'h00, 6'h20, 6'h01, 6'h21, 6'h06, 6'h26, 6'h0F, 6'h2F, 6'h1F, 6'h3F};
    rst_n = 1'b0; osc_en = 1'b0; halt = 1'b0; div_rst = 1'b0; cal_ctrl = '0;
    ftest_en = 1'b1; alarm_out_en = 1'b0; sqw_en = 1'b0; wdog_idle = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sec_tick && !centi_tick && !ftest_out, "R1 outputs in reset",
        {sec_tick, centi_tick, ftest_out}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sec_tick && !centi_tick && !ftest_out, "R1 outputs after release",
        {sec_tick, centi_tick, ftest_out}, 0);

    // Full correction cycle plus wrap, both signs, several magnitudes
    for (int i = 0; i < 10; i++) run(cals[i], 130, 1, 0, 0, 4'b1001);
    // Sparse oscillator enables through a whole cycle
    run(6'h26, 130, 3, 0, 0, 4'b1001);
    // Halt in mid-second, trimmed and plain seconds
    run(6'h21, 6, 1, 40, 50, 4'b1001);
    run(6'h06, 6, 2, 11, 33, 4'b1001);
    // Each test-output qualifier withdrawn in turn
    run(6'h21, 3, 1, 0, 0, 4'b0001);
    run(6'h21, 3, 1, 0, 0, 4'b1101);
    run(6'h21, 3, 1, 0, 0, 4'b1011);
    run(6'h21, 3, 1, 0, 0, 4'b1000);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule